// File: doc/BRIEF.md
# Processor-Side Load-Linked Reservation Tracker

This block sits in a processor-side cache controller and carries out the processor's half of load-linked / store-conditional (LL/SC) atomics. It holds exactly one reservation: a 40-bit address, a 32-bit key and a valid flag, plus an age counter. It watches processor LL, SC and store requests, decides whether a network command is needed, and sends the memory side's answer back to the processor.

A load-linked request opens a reservation and is forwarded as a one-flit LL command. The key and data that come back are stored and returned. A store-conditional request whose address misses the reservation fails on the spot, with no network traffic. On a hit, it consumes the reservation and is forwarded with the stored key. The memory side reports SC status as 0 = success, and the processor receives 1 = success. Plain stores are always forwarded, and they clear the reservation when their address matches it. A reservation that is never used dies after `AGE_LIMIT` cycles. Only one network transaction is in flight at a time, and the processor port stalls while one is pending.

Top module: `resv_tracker`

## Requirements
- R1: After reset `req_ready` is 1, `cmd_valid` and `rsp_valid` are 0, and no reservation is held: a first SC fails locally.
- R2: An LL request (`req_op` = 1) produces a command with `cmd_kind` = 1, `cmd_two_flit` = 0, the request address, and key and data fields of 0. The command stays valid and unchanged until `cmd_ready` is seen.
- R3: When the network answers an LL, `rsp_valid` pulses in the next cycle with `rsp_data` equal to the returned data. The returned key becomes the reservation key.
- R4: An SC (`req_op` = 2) with no reservation, or with an address different from the reserved one, returns `rsp_data` = 0 in the cycle after acceptance. It issues no command and leaves a held reservation intact.
- R5: An SC that hits emits `cmd_kind` = 2 with `cmd_two_flit` = 1, the address, the stored key and the write data, and it consumes the reservation, so a repeat SC fails locally.
- R6: For a forwarded SC, `rsp_data` is 1 when `nrsp_status` is 0 and 0 when `nrsp_status` is 1.
- R7: A store (`req_op` = 3) is always forwarded as `cmd_kind` = 3, `cmd_two_flit` = 1, with key 0, and is acknowledged with `rsp_data` = 0. A store to the reserved address clears the reservation, and a store to any other address keeps it.
- R8: An SC accepted on the k-th clock edge after the LL's acceptance edge hits when k <= `AGE_LIMIT` and fails locally when k > `AGE_LIMIT`.
- R9: `req_ready` is 0 from acceptance of a forwarded request until the edge that takes the network response, and it is 1 again in the cycle after.
- R10: A reservation that expires while its LL response is still awaited is invalid once that response returns.
- R11: A new LL replaces any held reservation: the old address no longer matches, and the new key is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_op | input | 2 | 1 = LL, 2 = SC, 3 = store, 0 = no-op |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Store / SC data |
| rsp_valid | output | 1 | One-cycle processor response strobe |
| rsp_data | output | DW | LL data, SC result (nonzero = success) or 0 |
| cmd_valid | output | 1 | Network command present |
| cmd_ready | input | 1 | Network takes the command |
| cmd_kind | output | 2 | 1 = LL, 2 = SC, 3 = write |
| cmd_two_flit | output | 1 | Command occupies two flits |
| cmd_addr | output | AW | Command address |
| cmd_key | output | KW | Reservation key (SC only) |
| cmd_data | output | DW | Write data |
| nrsp_valid | input | 1 | Network response present |
| nrsp_data | input | DW | Data returned for LL |
| nrsp_key | input | KW | Key returned for LL |
| nrsp_status | input | 1 | SC status, 0 = success |

## Verification
A stale valid flag or address would show up at the ports on the next SC. The request either fails with no command where a command was due, or it emits a command where a local zero was due, in the cycle right after acceptance. A wrong stored key appears as a bad `cmd_key` in the first cycle of the SC command. An age counter that is off by one moves the hit/miss boundary, so SCs are swept over every edge distance around `AGE_LIMIT`. The bench pins that boundary to a single cycle, with the status inversion checked on each forwarded SC.

// File: rtl/resv_pkg.sv
package resv_pkg;
  typedef enum logic [1:0] {
    OP_NOP = 2'd0,
    OP_LL  = 2'd1,
    OP_SC  = 2'd2,
    OP_ST  = 2'd3
  } proc_op_e;

  typedef enum logic [1:0] {
    NC_NONE = 2'd0,
    NC_LL   = 2'd1,
    NC_SC   = 2'd2,
    NC_WR   = 2'd3
  } net_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2
  } ctl_state_e;
endpackage

// File: rtl/resv_age.sv
module resv_age #(
  parameter int unsigned CW = 32,
  parameter logic [CW-1:0] LIMIT_M1 = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          live,
  output logic [CW-1:0] cnt,
  output logic          expire
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = start | live;
    cnt_d  = start ? '0 : cnt_q + 1'b1;
    expire = live && (cnt_q == LIMIT_M1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/resv_slot.sv
module resv_slot #(
  parameter int unsigned AW = 40,
  parameter int unsigned KW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set,
  input  logic [AW-1:0] set_addr,
  input  logic          drop,
  input  logic          key_we,
  input  logic [KW-1:0] key_in,
  input  logic [AW-1:0] cmp_addr,
  output logic          valid,
  output logic [AW-1:0] addr,
  output logic [KW-1:0] key,
  output logic          hit
);
  logic          valid_q, valid_d;
  logic [AW-1:0] addr_q;
  logic [KW-1:0] key_q;

  always_comb begin
    if (set)       valid_d = 1'b1;
    else if (drop) valid_d = 1'b0;
    else           valid_d = valid_q;
    hit = valid_q && (addr_q == cmp_addr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      key_q   <= '0;
    end else begin
      valid_q <= valid_d;
      if (set)    addr_q <= set_addr;
      if (key_we) key_q  <= key_in;
    end
  end

  assign valid = valid_q;
  assign addr  = addr_q;
  assign key   = key_q;
endmodule

// File: rtl/resv_ctrl.sv
module resv_ctrl
  import resv_pkg::*;
#(
  parameter int unsigned AW = 40,
  parameter int unsigned KW = 32,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  input  logic          slot_hit,
  input  logic [KW-1:0] slot_key,
  output logic          slot_set,
  output logic          slot_clr,
  output logic          key_we,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [1:0]    cmd_kind,
  output logic [AW-1:0] cmd_addr,
  output logic [KW-1:0] cmd_key,
  output logic [DW-1:0] cmd_data,
  input  logic          nrsp_valid,
  input  logic [DW-1:0] nrsp_data,
  input  logic          nrsp_status,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data
);
  ctl_state_e    state_q, state_d;
  net_cmd_e      kind_q, kind_d;
  logic [AW-1:0] addr_q;
  logic [KW-1:0] key_q, key_d;
  logic [DW-1:0] data_q, data_d;
  logic          rsp_v_q, rsp_v_d;
  logic [DW-1:0] rsp_q, rsp_d;
  logic          accept, local_fail, load_cmd, net_done;
  proc_op_e      op;

  always_comb begin
    op         = proc_op_e'(req_op);
    accept     = (state_q == ST_IDLE) && req_valid;
    local_fail = accept && (op == OP_SC) && !slot_hit;
    load_cmd   = accept && ((op == OP_LL) || (op == OP_ST) ||
                            ((op == OP_SC) && slot_hit));
    net_done   = (state_q == ST_WAIT) && nrsp_valid;
    slot_set   = accept && (op == OP_LL);
    slot_clr   = accept && ((op == OP_SC) || (op == OP_ST)) && slot_hit;
    key_we     = net_done && (kind_q == NC_LL);

    state_d = state_q;
    case (state_q)
      ST_IDLE: if (load_cmd)   state_d = ST_SEND;
      ST_SEND: if (cmd_ready)  state_d = ST_WAIT;
      ST_WAIT: if (nrsp_valid) state_d = ST_IDLE;
      default:                 state_d = ST_IDLE;
    endcase

    case (op)
      OP_LL:   kind_d = NC_LL;
      OP_SC:   kind_d = NC_SC;
      default: kind_d = NC_WR;
    endcase
    key_d  = (op == OP_SC) ? slot_key : '0;
    data_d = (op == OP_LL) ? '0 : req_wdata;

    rsp_v_d = local_fail || net_done;
    rsp_d   = '0;
    if (net_done) begin
      if (kind_q == NC_LL)      rsp_d = nrsp_data;
      else if (kind_q == NC_SC) rsp_d = {{(DW-1){1'b0}}, ~nrsp_status};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= NC_NONE;
      addr_q  <= '0;
      key_q   <= '0;
      data_q  <= '0;
      rsp_v_q <= 1'b0;
      rsp_q   <= '0;
    end else begin
      state_q <= state_d;
      rsp_v_q <= rsp_v_d;
      if (load_cmd) begin
        kind_q <= kind_d;
        addr_q <= req_addr;
        key_q  <= key_d;
        data_q <= data_d;
      end
      if (rsp_v_d) rsp_q <= rsp_d;
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign cmd_valid = (state_q == ST_SEND);
  assign cmd_kind  = kind_q;
  assign cmd_addr  = addr_q;
  assign cmd_key   = key_q;
  assign cmd_data  = data_q;
  assign rsp_valid = rsp_v_q;
  assign rsp_data  = rsp_q;
endmodule

// File: rtl/resv_tracker.sv
module resv_tracker #(
  parameter int unsigned     AW        = 40,
  parameter int unsigned     KW        = 32,
  parameter int unsigned     DW        = 32,
  parameter int unsigned     AGE_W     = 31,
  parameter longint unsigned AGE_LIMIT = 64'd2147483648
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [1:0]    cmd_kind,
  output logic          cmd_two_flit,
  output logic [AW-1:0] cmd_addr,
  output logic [KW-1:0] cmd_key,
  output logic [DW-1:0] cmd_data,
  input  logic          nrsp_valid,
  input  logic [DW-1:0] nrsp_data,
  input  logic [KW-1:0] nrsp_key,
  input  logic          nrsp_status
);
  localparam int unsigned     CW       = AGE_W + 1;
  localparam logic [CW-1:0]   LIMIT_M1 = CW'(AGE_LIMIT - 1);

  logic          slot_valid, slot_hit, slot_set, slot_clr, key_we, expire;
  logic [AW-1:0] slot_addr;
  logic [KW-1:0] slot_key;
  logic [CW-1:0] age_cnt;

  resv_ctrl #(.AW(AW), .KW(KW), .DW(DW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_ready  (req_ready),
    .slot_hit   (slot_hit),
    .slot_key   (slot_key),
    .slot_set   (slot_set),
    .slot_clr   (slot_clr),
    .key_we     (key_we),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_kind   (cmd_kind),
    .cmd_addr   (cmd_addr),
    .cmd_key    (cmd_key),
    .cmd_data   (cmd_data),
    .nrsp_valid (nrsp_valid),
    .nrsp_data  (nrsp_data),
    .nrsp_status(nrsp_status),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data)
  );

  resv_slot #(.AW(AW), .KW(KW)) u_slot (
    .clk     (clk),
    .rst_n   (rst_n),
    .set     (slot_set),
    .set_addr(req_addr),
    .drop    (slot_clr | expire),
    .key_we  (key_we),
    .key_in  (nrsp_key),
    .cmp_addr(req_addr),
    .valid   (slot_valid),
    .addr    (slot_addr),
    .key     (slot_key),
    .hit     (slot_hit)
  );

  resv_age #(.CW(CW), .LIMIT_M1(LIMIT_M1)) u_age (
    .clk   (clk),
    .rst_n (rst_n),
    .start (slot_set),
    .live  (slot_valid),
    .cnt   (age_cnt),
    .expire(expire)
  );

  assign cmd_two_flit = (cmd_kind != 2'd1);
endmodule

// File: rtl/resv_tracker_chk.sv
module resv_tracker_chk #(
  parameter int unsigned     AW        = 40,
  parameter int unsigned     KW        = 32,
  parameter int unsigned     DW        = 32,
  parameter int unsigned     CW        = 32,
  parameter longint unsigned AGE_LIMIT = 64'd2147483648
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [1:0]    req_op,
  input logic [AW-1:0] req_addr,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [1:0]    cmd_kind,
  input logic [AW-1:0] cmd_addr,
  input logic [KW-1:0] cmd_key,
  input logic          rsp_valid,
  input logic [DW-1:0] rsp_data,
  input logic          nrsp_valid,
  input logic          nrsp_status,
  input logic          slot_valid,
  input logic [AW-1:0] slot_addr,
  input logic [CW-1:0] age_cnt
);
  logic waiting;
  assign waiting = !req_ready && !cmd_valid;

  a_r2_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_kind) && $stable(cmd_key));

  a_r4_local_fail: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_op == 2'd2 && !slot_valid |=> rsp_valid && rsp_data == '0 && !cmd_valid);

  a_r5_sc_consumes: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_op == 2'd2 && slot_valid && slot_addr == req_addr
    |=> !slot_valid && cmd_valid && cmd_kind == 2'd2);

  a_r6_status_flip: assert property (@(posedge clk) disable iff (!rst_n)
    waiting && nrsp_valid && cmd_kind == 2'd2
    |=> rsp_valid && rsp_data == {{(DW-1){1'b0}}, ~$past(nrsp_status)});

  a_r8_age_bound: assert property (@(posedge clk) disable iff (!rst_n)
    slot_valid |-> 64'(age_cnt) < AGE_LIMIT);

  a_r9_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !req_ready);
endmodule

bind resv_tracker resv_tracker_chk #(
  .AW(AW), .KW(KW), .DW(DW), .CW(CW), .AGE_LIMIT(AGE_LIMIT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_op     (req_op),
  .req_addr   (req_addr),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .cmd_kind   (cmd_kind),
  .cmd_addr   (cmd_addr),
  .cmd_key    (cmd_key),
  .rsp_valid  (rsp_valid),
  .rsp_data   (rsp_data),
  .nrsp_valid (nrsp_valid),
  .nrsp_status(nrsp_status),
  .slot_valid (slot_valid),
  .slot_addr  (slot_addr),
  .age_cnt    (age_cnt)
);

// File: tb/resv_tracker_tb.sv
module resv_tracker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW  = 40;
  localparam int KW  = 32;
  localparam int DW  = 32;
  localparam int LIM = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_ready;
  logic [1:0]    req_op;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;
  logic          cmd_valid, cmd_ready, cmd_two_flit;
  logic [1:0]    cmd_kind;
  logic [AW-1:0] cmd_addr;
  logic [KW-1:0] cmd_key;
  logic [DW-1:0] cmd_data;
  logic          nrsp_valid, nrsp_status;
  logic [DW-1:0] nrsp_data;
  logic [KW-1:0] nrsp_key;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  int acc_cyc = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  resv_tracker #(.AW(AW), .KW(KW), .DW(DW), .AGE_W(31), .AGE_LIMIT(LIM)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind),
    .cmd_two_flit(cmd_two_flit), .cmd_addr(cmd_addr), .cmd_key(cmd_key),
    .cmd_data(cmd_data),
    .nrsp_valid(nrsp_valid), .nrsp_data(nrsp_data), .nrsp_key(nrsp_key),
    .nrsp_status(nrsp_status)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // Called at a negedge; returns at the negedge after the acceptance edge.
  task automatic issue(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    acc_cyc = cyc;
    req_valid = 1'b0;
  endtask

  task automatic local_fail(input string rq);
    chk(rsp_valid == 1'b1, rq, "local rsp_valid", 64'(rsp_valid), 64'd1);
    chk(rsp_data == '0, rq, "local rsp_data", 64'(rsp_data), 64'd0);
    chk(cmd_valid == 1'b0, rq, "no command", 64'(cmd_valid), 64'd0);
  endtask

  task automatic serve(input int rwait, input int dwait, input logic [1:0] ekind,
                       input logic [AW-1:0] ea, input logic [KW-1:0] ek,
                       input logic [DW-1:0] ed, input logic [DW-1:0] nd,
                       input logic [KW-1:0] nk, input logic ns,
                       output logic [DW-1:0] got, input string rq);
    chk(cmd_valid == 1'b1, rq, "cmd_valid", 64'(cmd_valid), 64'd1);
    chk(cmd_kind == ekind, rq, "cmd_kind", 64'(cmd_kind), 64'(ekind));
    chk(cmd_two_flit == (ekind != 2'd1), rq, "cmd_two_flit", 64'(cmd_two_flit), 64'(ekind != 2'd1));
    chk(cmd_addr == ea, rq, "cmd_addr", 64'(cmd_addr), 64'(ea));
    chk(cmd_key == ek, rq, "cmd_key", 64'(cmd_key), 64'(ek));
    chk(cmd_data == ed, rq, "cmd_data", 64'(cmd_data), 64'(ed));
    for (int i = 0; i < rwait; i++) begin
      @(negedge clk);
      chk(cmd_valid && !req_ready && cmd_addr == ea && cmd_kind == ekind,
          "R2/R9", "held command", 64'(cmd_addr), 64'(ea));
    end
    cmd_ready = 1'b1;
    @(negedge clk);
    cmd_ready = 1'b0;
    chk(!cmd_valid && !req_ready, "R9", "waiting stalls", 64'(req_ready), 64'd0);
    for (int i = 0; i < dwait; i++) @(negedge clk);
    nrsp_valid = 1'b1; nrsp_data = nd; nrsp_key = nk; nrsp_status = ns;
    @(negedge clk);
    nrsp_valid = 1'b0;
    chk(rsp_valid && req_ready, rq, "response and ready", 64'({rsp_valid, req_ready}), 64'd3);
    got = rsp_data;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] got;
    logic [AW-1:0] a, b;
    logic [KW-1:0] k1, k2;
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_addr = '0; req_wdata = '0;
    cmd_ready = 1'b0; nrsp_valid = 1'b0; nrsp_data = '0; nrsp_key = '0; nrsp_status = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "req_ready", 64'(req_ready), 64'd1);
    chk(!cmd_valid && !rsp_valid, "R1", "idle outputs", 64'({cmd_valid, rsp_valid}), 64'd0);
    issue(2'd2, 40'h12_3456_7890, 32'h1);
    local_fail("R1");
    @(negedge clk);

    // Age sweep across the expiry boundary, alternating SC status
    for (int x = 0; x <= LIM; x++) begin
      int ll_cyc, k;
      a  = 40'hF0_0000_0000 | 40'(x * 8);
      k1 = 32'hA500_0000 + 32'(x);
      issue(2'd1, a, 32'hDEAD);
      ll_cyc = acc_cyc;
      serve(0, 0, 2'd1, a, '0, '0, 32'h7700 + 32'(x), k1, 1'b0, got, "R2");
      chk(got == 32'h7700 + 32'(x), "R3", "LL data", 64'(got), 64'(32'h7700 + 32'(x)));
      for (int j = 0; j < x; j++) @(negedge clk);
      issue(2'd2, a, 32'hC0DE_0000 + 32'(x));
      k = acc_cyc - ll_cyc;
      if (k <= LIM) begin
        serve(0, 0, 2'd2, a, k1, 32'hC0DE_0000 + 32'(x), '0, '0, x[0], got, "R8");
        chk(got == {31'b0, ~x[0]}, "R6", "status inverted", 64'(got), 64'(~x[0]));
        @(negedge clk);
        issue(2'd2, a, 32'h5);
        local_fail("R5");
      end else begin
        local_fail("R8");
      end
      @(negedge clk);
    end

    // Address mismatch leaves reservation intact
    a = 40'h01_0000_1000; k1 = 32'h1111_2222;
    issue(2'd1, a, '0);
    serve(0, 1, 2'd1, a, '0, '0, 32'h42, k1, 1'b0, got, "R3");
    issue(2'd2, a + 40'd4, 32'h9);
    local_fail("R4");
    @(negedge clk);
    issue(2'd2, a, 32'h9);
    serve(0, 0, 2'd2, a, k1, 32'h9, '0, '0, 1'b1, got, "R4");
    chk(got == '0, "R6", "failure maps to 0", 64'(got), 64'd0);

    // Store to another address keeps it; store to same address drops it
    k1 = 32'h3333_4444; b = 40'h02_0000_0000;
    issue(2'd1, a, '0);
    serve(2, 0, 2'd1, a, '0, '0, 32'h1, k1, 1'b0, got, "R2");
    issue(2'd3, b, 32'hBEEF);
    serve(0, 0, 2'd3, b, '0, 32'hBEEF, '0, '0, 1'b0, got, "R7");
    chk(got == '0, "R7", "store ack", 64'(got), 64'd0);
    issue(2'd2, a, 32'h77);
    serve(0, 0, 2'd2, a, k1, 32'h77, '0, '0, 1'b0, got, "R7");
    chk(got == 32'd1, "R6", "success maps to 1", 64'(got), 64'd1);
    issue(2'd1, a, '0);
    serve(0, 0, 2'd1, a, '0, '0, 32'h1, k1, 1'b0, got, "R7");
    issue(2'd3, a, 32'hF00D);
    serve(3, 2, 2'd3, a, '0, 32'hF00D, '0, '0, 1'b0, got, "R7");
    issue(2'd2, a, 32'h1);
    local_fail("R7");
    @(negedge clk);

    // Expiry while the LL answer is outstanding
    issue(2'd1, a, '0);
    serve(0, LIM + 3, 2'd1, a, '0, '0, 32'h5, 32'h5555, 1'b0, got, "R10");
    issue(2'd2, a, 32'h1);
    local_fail("R10");
    @(negedge clk);

    // A second LL replaces the first
    k1 = 32'h6666_0001; k2 = 32'h6666_0002;
    issue(2'd1, a, '0);
    serve(0, 0, 2'd1, a, '0, '0, 32'h1, k1, 1'b0, got, "R11");
    issue(2'd1, b, '0);
    serve(1, 0, 2'd1, b, '0, '0, 32'h2, k2, 1'b0, got, "R11");
    issue(2'd2, a, 32'h1);
    local_fail("R11");
    @(negedge clk);
    issue(2'd2, b, 32'h2);
    serve(0, 0, 2'd2, b, k2, 32'h2, '0, '0, 1'b0, got, "R11");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule